// File: doc/BRIEF.md
# ADC result FIFO with temperature slot

This block sits between a converter core and a host serial port. Conversion results arrive as 12-bit words with a one-cycle write strobe. They are queued in a 16-entry ring that drops its oldest entry when a new result comes in while it is full. Temperature readings arrive on a separate strobe and go into a single holding register. A newer reading replaces an older one that has not yet been read.

The host reads by pulling chip select low and toggling a serial clock. At the start of each frame the block picks one word. A pending temperature reading takes precedence over queued conversion results. If neither is present, the frame is all zeros. The chosen word is shifted out most significant bit first as 16 bits: four zero bits followed by the 12-bit value. The entry is consumed only when the full frame has been clocked before chip select returns high. Chip select, serial clock and the strobes are all sampled on the block clock.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset, `adc_count` is 0, `temp_valid` is 0 and `sdo` is 0.
- R2: Each frame carries 16 bits, MSB first: bits 15..12 are zero and bits 11..0 are the stored value. The first bit appears once a chip-select fall has been seen, and each later bit appears after a serial-clock fall has been seen.
- R3: Conversion results are read oldest first, and `adc_count` rises by one per write up to 16.
- R4: A conversion write into a full ring discards the oldest entry and keeps the new one, and `adc_count` stays at 16.
- R5: While a temperature reading is pending, a frame delivers it ahead of any queued conversion result.
- R6: A temperature write replaces any unread reading, and the 12-bit two's complement value is delivered unchanged.
- R7: A frame started with nothing stored drives `sdo` low for all 16 bits and changes no state.
- R8: An entry is consumed only if at least 16 serial-clock rises occurred before chip select rose. A shorter frame leaves the entry and the counts untouched.
- R9: Whenever chip select has been high for a sampled cycle, `sdo` is 0.
- R10: If the entry being read is displaced during its frame (by a ring overwrite, or by a newer temperature reading), completing the frame consumes nothing further.
- R11: `adc_count` reports the number of stored conversion results (0 to 16), and `temp_valid` reports whether a temperature reading is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_wr | input | 1 | Conversion result strobe |
| adc_data | input | DATA_W | Conversion result |
| temp_wr | input | 1 | Temperature result strobe |
| temp_data | input | DATA_W | Temperature result, two's complement |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| adc_count | output | clog2(DEPTH+1) | Stored conversion result count |
| temp_valid | output | 1 | Temperature reading pending |

## Verification
The assertions assume that `cs_n` and `sclk` are already synchronous to `clk` and that each level lasts several clock cycles. They also assume that the serial clock idles low when a frame begins, so every edge seen on the pins is seen once. The bench drives all inputs on the falling edge of `clk` and holds each serial-clock phase for four cycles. It keeps `sclk` low while `cs_n` changes, and it pulses each strobe for exactly one cycle. Writes during a frame are issued only in the low phase of the serial clock, after several bits have already been delivered.

// File: rtl/adcfifo_pkg.sv
package adcfifo_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TEMP = 2'd1,
        SRC_ADC  = 2'd2
    } src_e;
endpackage

// File: rtl/adc_ring.sv
module adc_ring #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           pop,
    output logic [DATA_W-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } ring_st_t;

    ring_st_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic full;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        full = (st_q.cnt == CNT_W'(DEPTH));
        if (wr_en) begin
            st_d.wr = step(st_q.wr);
        end
        // the oldest entry leaves on a pop, or when a write lands on a full ring
        if (pop || (wr_en && full)) begin
            st_d.rd = step(st_q.rd);
        end
        if (wr_en && !pop && !full) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && !wr_en) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[st_q.wr] <= wr_data;
        end
    end

    assign head  = mem[st_q.rd];
    assign count = st_q.cnt;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)); // R3
    AST_FULL_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(DEPTH) && wr_en && !pop) |=> st_q.cnt == CNT_W'(DEPTH)); // R4
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.cnt != '0); // R8
endmodule

// File: rtl/temp_slot.sv
module temp_slot #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.valid = 1'b0;
        end
        // a fresh reading wins over a clear in the same cycle
        if (wr_en) begin
            st_d.valid = 1'b1;
            st_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;

    AST_TEMP_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid && data == $past(wr_data))); // R6
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [WORD_W-1:0] load_word,
    output logic              sdo,
    output logic              frame_start,
    output logic              frame_done
);
    localparam int BC_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              cs;
        logic              sck;
        logic [WORD_W-1:0] shift;
        logic [BC_W-1:0]   rises;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic cs_fall, cs_rise, sck_rise, sck_fall;

    always_comb begin
        cs_fall  = st_q.cs && !cs_n;
        cs_rise  = !st_q.cs && cs_n;
        sck_rise = !st_q.sck && sclk;
        sck_fall = st_q.sck && !sclk;
        st_d     = st_q;
        st_d.cs  = cs_n;
        st_d.sck = sclk;
        if (cs_n) begin
            st_d.shift = '0;
            st_d.rises = '0;
        end else if (cs_fall) begin
            st_d.shift = load_word;
            st_d.rises = '0;
        end else begin
            if (sck_fall) begin
                st_d.shift = {st_q.shift[WORD_W-2:0], 1'b0};
            end
            if (sck_rise && st_q.rises != BC_W'(WORD_W)) begin
                st_d.rises = st_q.rises + 1'b1;
            end
        end
        frame_start = cs_fall;
        frame_done  = cs_rise && (st_q.rises == BC_W'(WORD_W));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cs    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo = st_q.shift[WORD_W-1];

    AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !sdo); // R9
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DATA_W = 12,
    parameter int WORD_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adc_wr,
    input  logic [DATA_W-1:0]          adc_data,
    input  logic                       temp_wr,
    input  logic [DATA_W-1:0]          temp_data,
    input  logic                       cs_n,
    input  logic                       sclk,
    output logic                       sdo,
    output logic [$clog2(DEPTH+1)-1:0] adc_count,
    output logic                       temp_valid
);
    import adcfifo_pkg::*;

    localparam int PAD_W = WORD_W - DATA_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        src_e src;
        logic disp;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [DATA_W-1:0] ring_head, t_data;
    logic [WORD_W-1:0] load_word;
    logic frame_start, frame_done, pop_adc, clr_temp, ring_full;
    src_e pick;

    adc_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_en(adc_wr), .wr_data(adc_data),
        .pop(pop_adc), .head(ring_head), .count(adc_count)
    );

    temp_slot #(.DATA_W(DATA_W)) u_temp (
        .clk(clk), .rst_n(rst_n), .wr_en(temp_wr), .wr_data(temp_data),
        .clr(clr_temp), .valid(temp_valid), .data(t_data)
    );

    serial_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .load_word(load_word), .sdo(sdo),
        .frame_start(frame_start), .frame_done(frame_done)
    );

    always_comb begin
        ring_full = (adc_count == CNT_W'(DEPTH));
        if (temp_valid) begin
            pick      = SRC_TEMP;
            load_word = {{PAD_W{1'b0}}, t_data};
        end else if (adc_count != '0) begin
            pick      = SRC_ADC;
            load_word = {{PAD_W{1'b0}}, ring_head};
        end else begin
            pick      = SRC_NONE;
            load_word = '0;
        end

        st_d = st_q;
        if (frame_start) begin
            st_d.src  = pick;
            st_d.disp = (pick == SRC_TEMP && temp_wr) ||
                        (pick == SRC_ADC && adc_wr && ring_full);
        end else if (cs_n) begin
            st_d.src  = SRC_NONE;
            st_d.disp = 1'b0;
        end else begin
            // the word in flight lost its storage before the frame finished
            if (st_q.src == SRC_TEMP && temp_wr) begin
                st_d.disp = 1'b1;
            end
            if (st_q.src == SRC_ADC && adc_wr && ring_full) begin
                st_d.disp = 1'b1;
            end
        end

        pop_adc  = frame_done && st_q.src == SRC_ADC  && !st_q.disp;
        clr_temp = frame_done && st_q.src == SRC_TEMP && !st_q.disp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{src: SRC_NONE, disp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !temp_valid && adc_count == '0) |=> !sdo); // R7
    AST_SHORT_FRAME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !$past(cs_n) && !frame_done && !adc_wr) |=> adc_count == $past(adc_count)); // R8
endmodule

// File: tb/adc_result_fifo_test.sv
`timescale 1ns/1ps
module adc_result_fifo_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adc_wr = 1'b0, temp_wr = 1'b0, cs_n = 1'b1, sclk = 1'b0;
    logic [11:0] adc_data = '0, temp_data = '0;
    logic sdo, temp_valid;
    logic [4:0] adc_count;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    int     adc_m[$];
    logic [11:0] temp_m = '0;
    bit     temp_v = 1'b0;

    int    exp_q[$];
    int    got_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    adc_result_fifo uut (
        .clk(clk), .rst_n(rst_n), .adc_wr(adc_wr), .adc_data(adc_data),
        .temp_wr(temp_wr), .temp_data(temp_data), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo), .adc_count(adc_count), .temp_valid(temp_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_status(input string req);
        check(int'(adc_count) == adc_m.size(), req, int'(adc_count), adc_m.size());
        check(temp_valid == temp_v, req, int'(temp_valid), int'(temp_v));
    endtask

    task automatic adc_write(input logic [11:0] v);
        adc_wr = 1'b1; adc_data = v;
        @(negedge clk);
        adc_wr = 1'b0;
        if (adc_m.size() == 16) void'(adc_m.pop_front());
        adc_m.push_back(int'(v));
    endtask

    task automatic temp_write(input logic [11:0] v);
        temp_wr = 1'b1; temp_data = v;
        @(negedge clk);
        temp_wr = 1'b0;
        temp_m = v; temp_v = 1'b1;
    endtask

    // driver: runs one frame, pushes the expected word; the monitor compares
    task automatic read_frame(input int nbits, input string req,
                              input bit mid_adc, input logic [11:0] mav,
                              input bit mid_tmp, input logic [11:0] mtv);
        int src;
        int expw;
        int got;
        bit disp;
        got = 0; disp = 1'b0;
        if (temp_v) begin src = 1; expw = int'(temp_m); end
        else if (adc_m.size() != 0) begin src = 2; expw = adc_m[0]; end
        else begin src = 0; expw = 0; end
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            got = (got << 1) | int'(sdo);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            if (i == 4) begin
                if (mid_adc) begin
                    if (src == 2 && adc_m.size() == 16) disp = 1'b1;
                    adc_write(mav);
                end
                if (mid_tmp) begin
                    if (src == 1) disp = 1'b1;
                    temp_write(mtv);
                end
            end
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sdo == 1'b0, "R9", int'(sdo), 0);
        if (nbits == 16 && !disp) begin
            if (src == 1) temp_v = 1'b0;
            if (src == 2) void'(adc_m.pop_front());
        end
        exp_q.push_back(expw >> (16 - nbits));
        got_q.push_back(got);
        tag_q.push_back(req);
    endtask

    initial begin : monitor
        forever begin
            wait (got_q.size() != 0);
            begin
                int g, e;
                string t;
                g = got_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        // R1: reset state
        check(sdo == 1'b0, "R1", int'(sdo), 0);
        check(adc_count == 5'd0, "R1", int'(adc_count), 0);
        check(temp_valid == 1'b0, "R1", int'(temp_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: empty read is zero, nothing changes
        read_frame(16, "R7", 1'b0, '0, 1'b0, '0);
        check_status("R7");

        // R2 / R3: framing and order
        adc_write(12'hABC); adc_write(12'h123); adc_write(12'hFFF);
        check_status("R11");
        read_frame(16, "R2", 1'b0, '0, 1'b0, '0);
        read_frame(16, "R3", 1'b0, '0, 1'b0, '0);
        read_frame(16, "R2", 1'b0, '0, 1'b0, '0);
        check_status("R3");
        read_frame(16, "R7", 1'b0, '0, 1'b0, '0);

        // R4: overwrite oldest
        for (int i = 0; i < 20; i++) adc_write(12'((i * 145 + 5) & 12'hFFF));
        check(adc_count == 5'd16, "R4", int'(adc_count), 16);
        for (int i = 0; i < 16; i++) read_frame(16, "R4", 1'b0, '0, 1'b0, '0);
        check_status("R4");

        // R5 / R6: temperature priority and replacement
        adc_write(12'h111); adc_write(12'h222);
        temp_write(12'h7F0); temp_write(12'hF9C);
        check_status("R11");
        read_frame(16, "R6", 1'b0, '0, 1'b0, '0);
        check_status("R5");
        read_frame(16, "R5", 1'b0, '0, 1'b0, '0);
        read_frame(16, "R3", 1'b0, '0, 1'b0, '0);

        // R8: aborted frames keep the entry
        adc_write(12'h5A5);
        read_frame(8, "R8", 1'b0, '0, 1'b0, '0);
        check_status("R8");
        read_frame(16, "R8", 1'b0, '0, 1'b0, '0);
        temp_write(12'h801);
        read_frame(15, "R8", 1'b0, '0, 1'b0, '0);
        check_status("R8");
        read_frame(16, "R8", 1'b0, '0, 1'b0, '0);
        check_status("R8");

        // R10: displacement during a frame
        for (int i = 0; i < 16; i++) adc_write(12'(12'h300 + i));
        read_frame(16, "R10", 1'b1, 12'hEEE, 1'b0, '0);
        check(adc_count == 5'd16, "R10", int'(adc_count), 16);
        read_frame(16, "R10", 1'b0, '0, 1'b0, '0);
        check_status("R10");
        temp_write(12'h0AA);
        read_frame(16, "R10", 1'b0, '0, 1'b1, 12'h0BB);
        check_status("R10");
        read_frame(16, "R10", 1'b0, '0, 1'b0, '0);
        check_status("R11");

        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule